// File: doc/BRIEF.md
# Octal Double-Buffered DAC Register Bank

This block sits behind a serial receiver and turns 32-bit command words into the digital state of an eight-channel converter. Every channel owns two registers: a staging (input) register that commands write, and an output (DAC) register whose value is the code presented to the converter. Codes move from staging to output either by command, by holding the active-low load pin low, or automatically for channels whose bit is set in a software override mask.

Besides the code path the block keeps a programmable clear code that the active-low clear pin forces into every register without waiting for a clock. It also holds a two-bit power-down mode per channel and a reference-enable flag. A power-on reset or a reset command returns everything to a build-time default, either zero or midscale.

Top module: `octal_dac_regbank`

## Requirements
- R1: In a command word, bits 27:24 are the opcode, bits 23:20 the address and bits 19:4 the 16-bit code; bits 31:28 and 3:0 have no effect on code-carrying opcodes.
- R2: Address values 0..7 select channel 0..7, 15 selects every channel, and 8..14 select no channel.
- R3: Opcode 0 writes the staging register of the addressed channels and leaves their output code unchanged (load pin high, mask bit clear); opcode 1 copies staging to output for the addressed channels.
- R4: Opcode 2 writes the addressed staging registers and then copies staging to output on all channels; opcode 3 writes and copies for the addressed channels only.
- R5: On every clock edge at which load_n is low, each output register takes its staging value, including a value written at that same edge.
- R6: Opcode 6 stores bits 7:0 as the override mask (bit i for channel i); a channel with its bit set copies to output at every write of its staging register, whatever load_n is. The mask is zero after reset.
- R7: Opcode 5 sets the clear code from bits 1:0: 00 gives 0x0000, 01 gives 0x8000, 10 gives 0xFFFF, 11 keeps the stored code. The clear code is 0x0000 after reset.
- R8: While clear_n is low, all staging and output registers hold the clear code, reached asynchronously; commands and load_n are ignored during that time.
- R9: Opcode 4 writes the mode in bits 9:8 (00 normal, 01 1k to ground, 10 100k to ground, 11 high impedance) into every channel whose bit in 7:0 is set; pd_modes bits [2i+1:2i] hold channel i. Output codes are unchanged by it.
- R10: Opcode 8 sets the reference enable from bit 0; it is off after reset.
- R11: rst_n low, or opcode 7, sets every staging and output register to 0x0000 (RESET_MID=0) or 0x8000 (RESET_MID=1), and clears mask, clear code, power-down modes and reference enable.
- R12: Opcodes 9 through 15 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| cmd_word | input | 32 | Command word |
| cmd_valid | input | 1 | Command word is valid this cycle |
| load_n | input | 1 | Active-low load strobe, sampled at the clock |
| clear_n | input | 1 | Asynchronous active-low clear to the stored clear code |
| dac_codes | output | NCH*16 | Output codes, channel i at bits [16i+15:16i] |
| pd_modes | output | NCH*2 | Power-down modes, channel i at bits [2i+1:2i] |
| ref_on | output | 1 | Internal reference enable |

## Verification
The bench builds the block with eight channels and RESET_MID=1, so a reset value of 0x8000 can be told apart from the default clear code 0x0000 and from any state left by a clear. With that build, reset and a clear pulse leave different fingerprints on every output, and a missed soft reset or a wrong reset constant shows up at once. Random command streams with mixed load pulses and mask settings are compared every cycle against a model of both register stages.

// File: rtl/dacbank_pkg.sv
package dacbank_pkg;
  localparam int CODE_W = 16;
  localparam int WORD_W = 32;

  localparam logic [3:0] OP_WR_IN      = 4'h0;
  localparam logic [3:0] OP_UPD        = 4'h1;
  localparam logic [3:0] OP_WR_UPD_ALL = 4'h2;
  localparam logic [3:0] OP_WR_UPD     = 4'h3;
  localparam logic [3:0] OP_PWRDN      = 4'h4;
  localparam logic [3:0] OP_CLRCODE    = 4'h5;
  localparam logic [3:0] OP_LDMASK     = 4'h6;
  localparam logic [3:0] OP_RESET      = 4'h7;
  localparam logic [3:0] OP_REFSET     = 4'h8;
  localparam logic [3:0] ADDR_ALL      = 4'hF;

  // clear-code field to stored value (field 11 is filtered out before use)
  function automatic logic [CODE_W-1:0] clear_value(input logic [1:0] f);
    case (f)
      2'b01:   clear_value = {1'b1, {(CODE_W-1){1'b0}}};
      2'b10:   clear_value = {CODE_W{1'b1}};
      default: clear_value = '0;
    endcase
  endfunction

  function automatic logic [CODE_W-1:0] reset_value(input bit mid);
    reset_value = mid ? {1'b1, {(CODE_W-1){1'b0}}} : '0;
  endfunction
endpackage

// File: rtl/dacbank_cmd_decoder.sv
module dacbank_cmd_decoder
  import dacbank_pkg::*;
#(
  parameter int NCH = 8
) (
  input  logic [WORD_W-1:0] cmd_word,
  input  logic              cmd_valid,
  input  logic              clear_n,
  output logic [NCH-1:0]    wr_ch,
  output logic [NCH-1:0]    upd_cmd,
  output logic [CODE_W-1:0] data,
  output logic              soft_rst,
  output logic              pd_we,
  output logic [1:0]        pd_mode,
  output logic [NCH-1:0]    ch_bits,
  output logic              clr_we,
  output logic [1:0]        clr_field,
  output logic              mask_we,
  output logic              ref_we,
  output logic              ref_val
);
  logic [3:0]     op;
  logic [3:0]     addr;
  logic [NCH-1:0] sel;
  logic           eff;

  assign op        = cmd_word[27:24];
  assign addr      = cmd_word[23:20];
  assign data      = cmd_word[19:4];
  assign pd_mode   = cmd_word[9:8];
  assign ch_bits   = cmd_word[NCH-1:0];
  assign clr_field = cmd_word[1:0];
  assign ref_val   = cmd_word[0];
  assign eff       = cmd_valid & clear_n;

  for (genvar i = 0; i < NCH; i++) begin : g_sel
    assign sel[i] = (addr == ADDR_ALL) || (addr == 4'(i));
  end

  always_comb begin
    wr_ch   = '0;
    upd_cmd = '0;
    if (eff) begin
      case (op)
        OP_WR_IN:      wr_ch = sel;
        OP_UPD:        upd_cmd = sel;
        OP_WR_UPD_ALL: begin wr_ch = sel; upd_cmd = '1; end
        OP_WR_UPD:     begin wr_ch = sel; upd_cmd = sel; end
        default:       ;
      endcase
    end
  end

  assign soft_rst = eff && (op == OP_RESET);
  assign pd_we    = eff && (op == OP_PWRDN);
  assign clr_we   = eff && (op == OP_CLRCODE) && (clr_field != 2'b11);
  assign mask_we  = eff && (op == OP_LDMASK);
  assign ref_we   = eff && (op == OP_REFSET);
endmodule

// File: rtl/dacbank_ctrl_regs.sv
module dacbank_ctrl_regs
  import dacbank_pkg::*;
#(
  parameter int NCH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              pd_we,
  input  logic [1:0]        pd_mode,
  input  logic [NCH-1:0]    ch_bits,
  input  logic              clr_we,
  input  logic [1:0]        clr_field,
  input  logic              mask_we,
  input  logic              ref_we,
  input  logic              ref_val,
  output logic [2*NCH-1:0]  pd_modes,
  output logic [CODE_W-1:0] clr_code,
  output logic [NCH-1:0]    mask,
  output logic              ref_on
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clr_code <= '0;
      mask     <= '0;
      ref_on   <= 1'b0;
    end else if (soft_rst) begin
      clr_code <= '0;
      mask     <= '0;
      ref_on   <= 1'b0;
    end else begin
      if (clr_we)  clr_code <= clear_value(clr_field);
      if (mask_we) mask     <= ch_bits;
      if (ref_we)  ref_on   <= ref_val;
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_pd
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   pd_modes[2*i +: 2] <= 2'b00;
      else if (soft_rst)            pd_modes[2*i +: 2] <= 2'b00;
      else if (pd_we && ch_bits[i]) pd_modes[2*i +: 2] <= pd_mode;
    end
  end
endmodule

// File: rtl/dacbank_channel.sv
module dacbank_channel
  import dacbank_pkg::*;
#(
  parameter logic [CODE_W-1:0] RST_VAL = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_n,
  input  logic [CODE_W-1:0] clr_code,
  input  logic              soft_rst,
  input  logic              wr,
  input  logic              upd,
  input  logic [CODE_W-1:0] data,
  output logic [CODE_W-1:0] in_q,
  output logic [CODE_W-1:0] dac_q
);
  logic [CODE_W-1:0] in_nxt;
  assign in_nxt = wr ? data : in_q;

  always_ff @(posedge clk or negedge rst_n or negedge clear_n) begin
    if (!rst_n) begin
      in_q  <= RST_VAL;
      dac_q <= RST_VAL;
    end else if (!clear_n) begin
      in_q  <= clr_code;
      dac_q <= clr_code;
    end else if (soft_rst) begin
      in_q  <= RST_VAL;
      dac_q <= RST_VAL;
    end else begin
      in_q <= in_nxt;
      if (upd) dac_q <= in_nxt;
    end
  end
endmodule

// File: rtl/octal_dac_regbank.sv
module octal_dac_regbank
  import dacbank_pkg::*;
#(
  parameter int NCH       = 8,
  parameter bit RESET_MID = 1'b0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [31:0]           cmd_word,
  input  logic                  cmd_valid,
  input  logic                  load_n,
  input  logic                  clear_n,
  output logic [NCH*16-1:0]     dac_codes,
  output logic [2*NCH-1:0]      pd_modes,
  output logic                  ref_on
);
  localparam logic [CODE_W-1:0] RST_VAL = reset_value(RESET_MID);

  logic [NCH-1:0]        wr_ch, upd_cmd, upd, ch_bits, mask;
  logic [CODE_W-1:0]     data, clr_code;
  logic                  soft_rst, pd_we, clr_we, mask_we, ref_we, ref_val;
  logic [1:0]            pd_mode, clr_field;
  logic [NCH*CODE_W-1:0] in_codes;

  dacbank_cmd_decoder #(.NCH(NCH)) dec_i (
    .cmd_word(cmd_word), .cmd_valid(cmd_valid), .clear_n(clear_n),
    .wr_ch(wr_ch), .upd_cmd(upd_cmd), .data(data), .soft_rst(soft_rst),
    .pd_we(pd_we), .pd_mode(pd_mode), .ch_bits(ch_bits),
    .clr_we(clr_we), .clr_field(clr_field), .mask_we(mask_we),
    .ref_we(ref_we), .ref_val(ref_val)
  );

  dacbank_ctrl_regs #(.NCH(NCH)) ctl_i (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .pd_we(pd_we), .pd_mode(pd_mode), .ch_bits(ch_bits),
    .clr_we(clr_we), .clr_field(clr_field), .mask_we(mask_we),
    .ref_we(ref_we), .ref_val(ref_val),
    .pd_modes(pd_modes), .clr_code(clr_code), .mask(mask), .ref_on(ref_on)
  );

  // copy staging to output: by command, by load pin, or by mask on write
  assign upd = upd_cmd | {NCH{~load_n}} | (wr_ch & mask);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    dacbank_channel #(.RST_VAL(RST_VAL)) ch_i (
      .clk(clk), .rst_n(rst_n), .clear_n(clear_n), .clr_code(clr_code),
      .soft_rst(soft_rst), .wr(wr_ch[i]), .upd(upd[i]), .data(data),
      .in_q(in_codes[i*CODE_W +: CODE_W]),
      .dac_q(dac_codes[i*CODE_W +: CODE_W])
    );
  end
endmodule

// File: rtl/dacbank_checker.sv
module dacbank_checker #(
  parameter int NCH       = 8,
  parameter bit RESET_MID = 1'b0
) (
  input logic              clk,
  input logic              rst_n,
  input logic [31:0]       cmd_word,
  input logic              cmd_valid,
  input logic              load_n,
  input logic              clear_n,
  input logic [NCH*16-1:0] dac_codes,
  input logic [NCH*16-1:0] in_codes,
  input logic [15:0]       clr_code
);
  localparam logic [15:0] RV = RESET_MID ? 16'h8000 : 16'h0000;

  AST_CLEAR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_n |-> (dac_codes == {NCH{clr_code}} && in_codes == {NCH{clr_code}})); // R8

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && !cmd_valid && clear_n) |=> (!clear_n || $stable(dac_codes))); // R3

  AST_LOAD_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_n && !cmd_valid && clear_n) |=> (!clear_n || dac_codes == $past(in_codes))); // R5

  AST_PD_KEEPS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && clear_n && load_n && cmd_word[27:24] == 4'h4) |=> (!clear_n || $stable(dac_codes))); // R9

  AST_SOFT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && clear_n && cmd_word[27:24] == 4'h7) |=> (!clear_n || dac_codes == {NCH{RV}})); // R11

  AST_CLR_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_code == 16'h0000 || clr_code == 16'h8000 || clr_code == 16'hFFFF)); // R7
endmodule

bind octal_dac_regbank dacbank_checker #(.NCH(NCH), .RESET_MID(RESET_MID)) chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_word(cmd_word), .cmd_valid(cmd_valid),
  .load_n(load_n), .clear_n(clear_n), .dac_codes(dac_codes),
  .in_codes(in_codes), .clr_code(clr_code)
);

// File: tb/octal_dac_regbank_tb_top.sv
module octal_dac_regbank_tb_top;
  localparam int N = 8;
  localparam logic [15:0] RV = 16'h8000;

  logic clk = 1'b0, rst_n = 1'b0, cmd_valid = 1'b0, load_n = 1'b1, clear_n = 1'b1;
  logic [31:0]    cmd_word = '0;
  logic [N*16-1:0] dac_codes;
  logic [2*N-1:0]  pd_modes;
  logic            ref_on;

  int vectors = 0, fails = 0;

  logic [15:0] m_in [N];
  logic [15:0] m_dac[N];
  logic [1:0]  m_pd [N];
  logic [7:0]  m_mask;
  logic [15:0] m_clr;
  logic        m_ref;

  always #10 clk = ~clk;

  octal_dac_regbank #(.NCH(N), .RESET_MID(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_word(cmd_word), .cmd_valid(cmd_valid),
    .load_n(load_n), .clear_n(clear_n), .dac_codes(dac_codes),
    .pd_modes(pd_modes), .ref_on(ref_on)
  );

  function automatic logic [15:0] exp_clear(input logic [1:0] f);
    logic [15:0] v;
    v = {16{f[1] & ~f[0]}};
    if (f == 2'b01) v = 16'h8000;
    return v;
  endfunction

  function automatic logic [31:0] mk(input logic [3:0] op, input logic [3:0] a,
                                     input logic [15:0] d, input logic [3:0] lo);
    return {4'h0, op, a, d, lo};
  endfunction

  task automatic model_reset();
    for (int i = 0; i < N; i++) begin m_in[i] = RV; m_dac[i] = RV; m_pd[i] = 2'b00; end
    m_mask = '0; m_clr = '0; m_ref = 1'b0;
  endtask

  task automatic model_apply(input logic [31:0] w, input logic v, input logic ld);
    logic [3:0] op, a;
    logic [N-1:0] wr, up;
    if (!clear_n) return;
    op = w[27:24]; a = w[23:20]; wr = '0; up = '0;
    if (v) begin
      if (op == 4'h7) begin model_reset(); return; end
      for (int i = 0; i < N; i++) begin
        bit hit;
        hit = (a == 4'hF) || (a == i);
        if (hit && (op == 4'h0 || op == 4'h2 || op == 4'h3)) begin
          m_in[i] = w[19:4]; wr[i] = 1'b1;
        end
        if ((hit && (op == 4'h1 || op == 4'h3)) || op == 4'h2) up[i] = 1'b1;
        if (op == 4'h4 && w[i]) m_pd[i] = w[9:8];
      end
      if (op == 4'h5 && w[1:0] != 2'b11) m_clr = exp_clear(w[1:0]);
      if (op == 4'h8) m_ref = w[0];
    end
    for (int i = 0; i < N; i++)
      if (!ld || up[i] || (wr[i] && m_mask[i])) m_dac[i] = m_in[i];
    if (v && op == 4'h6) m_mask = w[7:0];
  endtask

  task automatic check(input string tag);
    logic [N*16-1:0] ec;
    logic [2*N-1:0]  ep;
    for (int i = 0; i < N; i++) begin ec[i*16 +: 16] = m_dac[i]; ep[2*i +: 2] = m_pd[i]; end
    vectors++;
    if (dac_codes !== ec || pd_modes !== ep || ref_on !== m_ref) begin
      fails++;
      $display("FAIL %s: got codes=%h pd=%h ref=%b exp codes=%h pd=%h ref=%b",
               tag, dac_codes, pd_modes, ref_on, ec, ep, m_ref);
    end
  endtask

  task automatic step(input logic [31:0] w, input logic v, input logic ld, input string tag);
    @(negedge clk);
    cmd_word = w; cmd_valid = v; load_n = ld;
    @(posedge clk); #2;
    model_apply(w, v, ld);
    cmd_valid = 1'b0; load_n = 1'b1;
    check(tag);
  endtask

  task automatic pulse_clear(input string tag);
    @(negedge clk); #3;
    clear_n = 1'b0; #2;
    for (int i = 0; i < N; i++) begin m_in[i] = m_clr; m_dac[i] = m_clr; end
    check({tag, " async clear"});
    step(mk(4'h3, 4'hF, 16'h1357, 4'h0), 1'b1, 1'b1, {tag, " cmd ignored while clear"});
    step(mk(4'h6, 4'h0, 16'h0, 4'hF), 1'b1, 1'b0, {tag, " load/mask ignored while clear"});
    @(negedge clk); clear_n = 1'b1;
    step(mk(4'h1, 4'hF, 16'h0, 4'h0), 1'b1, 1'b1, {tag, " staging holds clear code"});
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog: run did not complete, exp completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1 check("R11 power-on reset midscale");

    step(mk(4'h0, 4'h2, 16'h1234, 4'h0), 1'b1, 1'b1, "R3 staging write, output unchanged");
    step(mk(4'h1, 4'h2, 16'h0000, 4'h0), 1'b1, 1'b1, "R3 copy staging to output");
    step({4'hA, 4'h3, 4'h5, 16'hBEEF, 4'h9}, 1'b1, 1'b1, "R1 ignored bits, write+update ch5");
    step(mk(4'h0, 4'hF, 16'h4444, 4'h0), 1'b1, 1'b1, "R2 broadcast staging write");
    step(mk(4'h1, 4'h9, 16'h0000, 4'h0), 1'b1, 1'b1, "R2 address 9 selects nothing");
    step(mk(4'h1, 4'hF, 16'h0000, 4'h0), 1'b1, 1'b1, "R2 broadcast update");
    step(mk(4'h0, 4'h0, 16'h0A0A, 4'h0), 1'b1, 1'b1, "R3 write ch0");
    step(mk(4'h2, 4'h1, 16'h1111, 4'h0), 1'b1, 1'b1, "R4 write ch1 update all");
    step(mk(4'h3, 4'h7, 16'h7777, 4'h0), 1'b1, 1'b1, "R4 write+update ch7");
    step(mk(4'h0, 4'h4, 16'hCAFE, 4'h0), 1'b1, 1'b1, "R5 stage ch4");
    step('0, 1'b0, 1'b0, "R5 load pin copies staging");
    step(mk(4'h0, 4'h6, 16'h6666, 4'h0), 1'b1, 1'b0, "R5 write and load same edge");
    step(mk(4'h6, 4'h0, 16'h0000, 4'hA), 1'b1, 1'b1, "R6 mask 0x0A");
    step(mk(4'h0, 4'h1, 16'hF001, 4'h0), 1'b1, 1'b1, "R6 masked ch1 follows write");
    step(mk(4'h0, 4'h2, 16'hF002, 4'h0), 1'b1, 1'b1, "R6 unmasked ch2 waits");
    step(mk(4'h0, 4'hF, 16'hABCD, 4'h0), 1'b1, 1'b1, "R6 broadcast with mask");
    pulse_clear("R8 default code");
    step(mk(4'h5, 4'h0, 16'h0000, 4'h2), 1'b1, 1'b1, "R7 clear code full scale");
    step(mk(4'h5, 4'h0, 16'h0000, 4'h3), 1'b1, 1'b1, "R7 field 11 keeps code");
    pulse_clear("R8 full-scale code");
    step(mk(4'h5, 4'h0, 16'h0000, 4'h1), 1'b1, 1'b1, "R7 clear code midscale");
    pulse_clear("R8 midscale code");
    step(mk(4'h3, 4'h3, 16'h3333, 4'h0), 1'b1, 1'b1, "R4 set ch3 before power-down");
    step(mk(4'h4, 4'h0, 16'h0028, 4'h1), 1'b1, 1'b1, "R9 mode 10 to ch0,ch7");
    step({8'h04, 8'h00, 8'h03, 8'h02}, 1'b1, 1'b1, "R9 mode 11 to ch1");
    step({8'h04, 8'h00, 8'h01, 8'h08}, 1'b1, 1'b1, "R9 mode 01 to ch3, code kept");
    step(mk(4'h8, 4'h0, 16'h0000, 4'h1), 1'b1, 1'b1, "R10 reference on");
    for (int op = 9; op < 16; op++)
      step({4'hF, 4'(op), 4'hF, 16'h5A5A, 4'hF}, 1'b1, 1'b1, "R12 unused opcode");
    step(mk(4'h8, 4'h0, 16'h0000, 4'h0), 1'b1, 1'b1, "R10 reference off");
    step(mk(4'h8, 4'h0, 16'h0000, 4'h1), 1'b1, 1'b1, "R10 reference on again");
    step(mk(4'h7, 4'h0, 16'h0000, 4'h0), 1'b1, 1'b1, "R11 soft reset");

    for (int k = 0; k < 2000; k++) begin
      logic [31:0] w;
      logic [3:0]  op, a;
      w  = $urandom;
      op = ($urandom % 16 < 11) ? 4'($urandom % 4) : 4'($urandom % 16);
      a  = ($urandom % 3 == 0) ? 4'hF : 4'($urandom % 16);
      w[27:24] = op; w[23:20] = a;
      step(w, ($urandom % 4) != 0, ($urandom % 6) != 0, "R1-random stream");
      if (k % 400 == 399) pulse_clear("R8 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule